// File: doc/BRIEF.md
# Modulo Timer Counter with Prescaler

This block is a 16-bit up-counter with a selectable clock source, a programmable wrap point and a sticky wrap flag. Its input is either the bus clock divided by a power of two from 1 to 64, or rising edges on an external timer pin after synchronization. When the count equals the modulo value, the next count enable returns it to 0x0000 and sets the flag. The flag can raise an interrupt request.

Software reaches the block through a byte-wide synchronous register bus. Offset 0 is the control/status byte. Offsets 1 and 2 return the count, high byte first. Offsets 3 and 4 hold the modulo value, high byte first. The block leaves reset with the counter stopped. A self-clearing command bit zeroes the counter and the prescaler. A separate output tells neighbouring capture logic when captures must be blocked.

Top module: `mod_timer`

## Requirements
- R1: After reset the control byte reads 0x20 (stop bit set, everything else 0), the count reads 0x0000, the modulo reads 0xFFFF, `irq_o` is 0 and `cap_block_o` is 1.
- R2: While control bit 5 (stop) is 1, the counter and the prescaler hold their values, and `cap_block_o` is 1. After bit 5 is written 0, counting resumes and `cap_block_o` is 0.
- R3: With control bits 2:0 (source select) at a value k from 0 to 6, the counter advances once every 2^k running bus-clock cycles.
- R4: With source select 7, the counter advances once for each rising edge on `tmr_pin_i`. The pin passes through two synchronizing flip-flops before edge detection, and the bus clock has no effect on the count.
- R5: When the count equals the modulo value (offset 3 = high byte, offset 4 = low byte), the next count enable loads 0x0000 and sets control bit 7 (flag). Writes to the count offsets 1 and 2 are ignored.
- R6: The flag is cleared only by a write to offset 0 with bit 7 = 0 that follows a read of offset 0 made while the flag was 1. Without such a read, a write of 0 leaves the flag set. A new wrap in the same cycle wins over the clear.
- R7: Writing 1 to control bit 7 never changes the flag.
- R8: `irq_o` is 1 exactly when the flag and control bit 6 (interrupt enable) are both 1.
- R9: Writing 1 to control bit 4 clears the counter and the prescaler in that cycle. Bit 4 always reads 0, and the other control fields take the written values. Setting the stop and clear bits in one write leaves the counter held at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_pin_i | input | 1 | External timer clock pin (asynchronous) |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_re_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | 8 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Wrap interrupt request |
| cap_block_o | output | 1 | Capture-inhibit indication to capture logic |

## Verification
The counting path is tried with four input patterns:
- divide-by-1, which pins down the exact cycle at which counting starts and stops;
- divide-by-4, which separates a correct prescaler tap from an off-by-one mask;
- a modulo of 5, which shows that the wrap happens on the enable after equality and that the flag sets at the same time;
- pulses on the external pin, which confirm that only pin edges advance the count in that mode.

The flag-clear handshake is tried in three ways: a write of 0 with no prior read, a write of 1 after a read, and a read followed by a write of 0. Only the last may clear the flag. Together with the combined stop-and-clear write, this separates a proper two-step clear from a plain write-to-clear.

// File: rtl/mod_timer_pkg.sv
package mod_timer_pkg;
    // Control/status byte bit positions (software-visible layout).
    localparam int CTL_FLAG = 7;
    localparam int CTL_IE   = 6;
    localparam int CTL_STOP = 5;
    localparam int CTL_CLR  = 4;

    // Offset of the control/status byte; count and modulo bytes follow.
    localparam int OFS_CTRL = 0;
endpackage

// File: rtl/mod_timer_presc.sv
module mod_timer_presc #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             pin,
    output logic             tick
);
    localparam int DIV_W   = (1 << SEL_W) - 2;
    localparam int SYNC_W  = 3;
    localparam logic [SEL_W-1:0] SEL_EXT = '1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SYNC_W-1:0] sync;
    } presc_t;

    presc_t st_d, st_q;
    logic [DIV_W-1:0] mask;
    logic             ext_mode;
    logic             pin_edge;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        ext_mode = (sel == SEL_EXT);
        pin_edge = st_q.sync[1] & ~st_q.sync[2];
        tick     = ext_mode ? pin_edge : ((st_q.div & mask) == mask);

        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_W-2:0], pin};
        if (clr) begin
            st_d.div = '0;
        end else if (run && !ext_mode) begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mod_timer_cnt.sv
module mod_timer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic step;

    always_comb begin
        step  = run && tick && !clr;
        wrap  = step && (st_q.cnt == modulo);
        count = st_q.cnt;

        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mod_timer_regs.sv
module mod_timer_regs
    import mod_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  modulo,
    output logic [SEL_W-1:0]  sel,
    output logic              stop,
    output logic              clr,
    output logic              flag,
    output logic              ie
);
    localparam int NB       = CNT_W / DATA_W;
    localparam int OFS_CNT  = OFS_CTRL + 1;
    localparam int OFS_MOD  = OFS_CNT + NB;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic             stop;
        logic [SEL_W-1:0] sel;
        logic             armed;
        logic [CNT_W-1:0] modulo;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr;
    logic  ctrl_rd;

    always_comb begin
        ctrl_wr = we && (int'(addr) == OFS_CTRL);
        ctrl_rd = re && (int'(addr) == OFS_CTRL);
        clr     = ctrl_wr && wdata[CTL_CLR];

        st_d = st_q;

        // Sticky flag: a new wrap takes priority over the two-step clear.
        if (wrap) begin
            st_d.flag = 1'b1;
        end else if (ctrl_wr && !wdata[CTL_FLAG] && st_q.armed) begin
            st_d.flag = 1'b0;
        end

        if (ctrl_wr) begin
            st_d.armed = 1'b0;
        end else if (ctrl_rd && st_q.flag) begin
            st_d.armed = 1'b1;
        end

        if (ctrl_wr) begin
            st_d.ie   = wdata[CTL_IE];
            st_d.stop = wdata[CTL_STOP];
            st_d.sel  = wdata[SEL_W-1:0];
        end

        for (int b = 0; b < NB; b++) begin
            if (we && int'(addr) == OFS_MOD + b) begin
                st_d.modulo[(NB-1-b)*DATA_W +: DATA_W] = wdata;
            end
        end

        rdata = '0;
        if (int'(addr) == OFS_CTRL) begin
            rdata[CTL_FLAG]    = st_q.flag;
            rdata[CTL_IE]      = st_q.ie;
            rdata[CTL_STOP]    = st_q.stop;
            rdata[SEL_W-1:0]   = st_q.sel;
        end
        for (int b = 0; b < NB; b++) begin
            if (int'(addr) == OFS_CNT + b) begin
                rdata = count[(NB-1-b)*DATA_W +: DATA_W];
            end
            if (int'(addr) == OFS_MOD + b) begin
                rdata = st_q.modulo[(NB-1-b)*DATA_W +: DATA_W];
            end
        end

        modulo = st_q.modulo;
        sel    = st_q.sel;
        stop   = st_q.stop;
        flag   = st_q.flag;
        ie     = st_q.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.stop   <= 1'b1;
            st_q.modulo <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mod_timer.sv
module mod_timer #(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_pin_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              cap_block_o
);
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] mod_val;
    logic [SEL_W-1:0] src_sel;
    logic             stop;
    logic             clr;
    logic             tick;
    logic             wrap;
    logic             flag;
    logic             ie;
    logic             run;

    assign run         = !stop;
    assign irq_o       = flag && ie;
    assign cap_block_o = stop;

    mod_timer_regs #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr_i),
        .wdata (bus_wdata_i),
        .we    (bus_we_i),
        .re    (bus_re_i),
        .count (cnt_val),
        .wrap  (wrap),
        .rdata (bus_rdata_o),
        .modulo(mod_val),
        .sel   (src_sel),
        .stop  (stop),
        .clr   (clr),
        .flag  (flag),
        .ie    (ie)
    );

    mod_timer_presc #(
        .SEL_W(SEL_W)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .clr  (clr),
        .sel  (src_sel),
        .pin  (tmr_pin_i),
        .tick (tick)
    );

    mod_timer_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .clr   (clr),
        .modulo(mod_val),
        .count (cnt_val),
        .wrap  (wrap)
    );
endmodule

// File: rtl/mod_timer_chk.sv
module mod_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              we,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  modv,
    input logic              stop,
    input logic              tick,
    input logic              flag,
    input logic              irq,
    input logic              cap_block
);
    logic ctrl_wr;
    assign ctrl_wr = we && (addr == '0);

    // R2: stopped counter holds unless the clear command is written
    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !(ctrl_wr && wdata[4])) |=> $stable(cnt));

    // R2: capture-inhibit output reflects the stop state
    assert_cap_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[5]) |=> cap_block);

    // R3: ordinary step advances by one
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && tick && cnt != modv && !(ctrl_wr && wdata[4])) |=> cnt == $past(cnt) + 1'b1);

    // R5: wrap at the modulo value sets the flag
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && tick && cnt == modv && !(ctrl_wr && wdata[4])) |=> (cnt == '0) && flag);

    // R6, R7: flag survives anything but a write of 0 to the control byte
    assert_flag_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctrl_wr && !wdata[7])) |=> flag);

    // R8: interrupt only with the flag set
    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R9: clear command zeroes the counter
    assert_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[4]) |=> cnt == '0);
endmodule

bind mod_timer mod_timer_chk #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr_i),
    .wdata    (bus_wdata_i),
    .we       (bus_we_i),
    .cnt      (cnt_val),
    .modv     (mod_val),
    .stop     (stop),
    .tick     (tick),
    .flag     (flag),
    .irq      (irq_o),
    .cap_block(cap_block_o)
);

// File: tb/mod_timer_test.sv
`timescale 1ns/1ps
module mod_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [7:0] rdata;
    logic       irq;
    logic       cap_block;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mod_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_pin_i  (pin),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_we_i   (we),
        .bus_re_i   (re),
        .bus_rdata_o(rdata),
        .irq_o      (irq),
        .cap_block_o(cap_block)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Inputs change at the falling edge; one rising edge commits the access.
    task automatic wr(input int a, input int d);
        addr  = 3'(a);
        wdata = 8'(d);
        we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = 3'(a);
        re   = 1'b1;
        #1;
        d = int'(rdata);
        @(posedge clk);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic get_count(output int c);
        int h, l;
        rd(1, h);
        rd(2, l);
        c = (h << 8) | l;
    endtask

    task automatic t_reset;
        int v;
        rd(0, v);  chk("R1 ctrl", v, 8'h20);
        get_count(v); chk("R1 count", v, 0);
        rd(3, v);  chk("R1 mod hi", v, 8'hFF);
        rd(4, v);  chk("R1 mod lo", v, 8'hFF);
        chk("R1 irq", irq, 0);
        chk("R1 cap_block", cap_block, 1);
        repeat (20) @(negedge clk);
        get_count(v); chk("R2 held after reset", v, 0);
    endtask

    task automatic t_div1;
        int v;
        wr(0, 8'h30);
        wr(0, 8'h00);
        chk("R2 cap_block running", cap_block, 0);
        repeat (9) @(negedge clk);
        wr(0, 8'h20);
        get_count(v); chk("R3 div1 count", v, 10);
        chk("R2 cap_block stopped", cap_block, 1);
        repeat (10) @(negedge clk);
        get_count(v); chk("R2 frozen", v, 10);
    endtask

    task automatic t_div4;
        int v;
        wr(0, 8'h30);
        get_count(v); chk("R9 cleared", v, 0);
        rd(0, v);  chk("R9 clear bit reads 0", v, 8'h20);
        wr(0, 8'h02);
        repeat (39) @(negedge clk);
        wr(0, 8'h22);
        get_count(v); chk("R3 div4 count", v, 10);
    endtask

    task automatic t_modulo;
        int v;
        wr(0, 8'h30);
        wr(3, 8'h00);
        wr(4, 8'h05);
        rd(4, v);  chk("R5 mod lo readback", v, 5);
        wr(1, 8'hAB);
        wr(2, 8'hCD);
        get_count(v); chk("R5 count writes ignored", v, 0);
        wr(0, 8'h00);
        repeat (6) @(negedge clk);
        wr(0, 8'h20);                       // write 0, no prior read
        get_count(v); chk("R5 wrapped then stepped", v, 1);
        chk("R8 irq off with ie=0", irq, 0);
        rd(0, v);  chk("R6 flag kept without read", v, 8'hA0);
        wr(0, 8'hA0);                       // write 1 to flag
        rd(0, v);  chk("R7 write 1 no effect", v, 8'hA0);
        wr(0, 8'h20);
        rd(0, v);  chk("R6 read then write 0 clears", v, 8'h20);
    endtask

    task automatic t_irq;
        int v;
        wr(0, 8'h30);
        wr(0, 8'h40);
        repeat (5) @(negedge clk);
        chk("R8 irq before wrap", irq, 0);
        @(negedge clk);
        chk("R8 irq after wrap", irq, 1);
        wr(0, 8'h60);
        rd(0, v);  chk("R8 status with ie", v, 8'hE0);
        wr(0, 8'h60);
        chk("R8 irq cleared", irq, 0);
    endtask

    task automatic t_ext;
        int v;
        wr(3, 8'hFF);
        wr(4, 8'hFF);
        wr(0, 8'h30);
        wr(0, 8'h07);
        repeat (20) @(negedge clk);
        get_count(v); chk("R4 idle pin no count", v, 0);
        for (int i = 0; i < 5; i++) begin
            pin = 1'b1;
            repeat (4) @(negedge clk);
            pin = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(0, 8'h27);
        get_count(v); chk("R4 pin edges counted", v, 5);
        wr(0, 8'h37);
        get_count(v); chk("R9 stop+clear holds zero", v, 0);
        repeat (10) @(negedge clk);
        get_count(v); chk("R9 still zero", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div1();
        t_div4();
        t_modulo();
        t_irq();
        t_ext();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule